// File: doc/BRIEF.md
# Leveled Interrupt Priority Dispatcher

This block decides which pending interrupt source a processor takes next. Every vector source holds a 3-bit priority level, where a smaller number is more urgent and the value 7 means the source is idle. The processor presents its status word, whose top three bits hold its current level. A source qualifies only if its level is strictly below that current level. Among the qualifying sources, the lowest vector number wins, whatever its level.

When the processor asks to take an interrupt, the block registers four results: the winning vector, the address of the vector-table entry, the address of the bank byte, and the status word to install. It then raises a one-cycle accept strobe. Table entries grow downward from the top of the address space.

At return from interrupt, the block compares the pending sources against the level in the saved status word. If one qualifies, it signals a chain to that source. Otherwise it signals an ordinary return. A counter of outstanding requests gates every request.

Top module: `ilvl_dispatch`

## Requirements
- R1: After reset, every vector holds level 7, the outstanding count is 0, `irq_req_o` is low, all strobes are low, `win_vec_o` is 0 and `pc_addr_o` is 0xFFFFFC.
- R2: A set stores the new level. It increments the outstanding count only when the new level differs from the stored one; writing level 7 over an active level still counts.
- R3: A clear sets the vector to level 7. It decrements the count only when the stored level was below 7, so the count never goes below zero. A clear and a set of the same vector in one cycle behave as the clear alone.
- R4: The outstanding count saturates at its all-ones value.
- R5: `irq_req_o` is high exactly when the count is nonzero and some vector's level is strictly below `cpu_status_i[15:13]`.
- R6: If `take_req_i` is high while R5's condition holds, then one cycle later `accept_o` pulses and `win_vec_o` gives the lowest-numbered vector whose level is below the current level.
- R7: The registered `pc_addr_o` equals 0xFFFFFC minus 4 times the winning vector, modulo 2^24, and `bank_addr_o` equals `pc_addr_o` + 2.
- R8: On acceptance, `new_status_o` is `cpu_status_i` with bit 5 (supervisor stack) set and bits 15:13 replaced by the winner's level.
- R9: `reti_req_i` takes precedence over `take_req_i`. It arbitrates against `saved_status_i[15:13]`. If the count is nonzero and a vector qualifies, `chain_o` pulses and `new_status_o` is `saved_status_i` with bit 5 set and the winner's level. Otherwise `ret_o` pulses.
- R10: A take request with no qualifying source, or with the count at zero, produces no strobe and leaves `win_vec_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_valid_i | input | 1 | Write a level to one vector |
| set_vec_i | input | $clog2(NUM_VEC) | Vector to write |
| set_level_i | input | 3 | Level to write |
| clr_valid_i | input | 1 | Clear one vector to level 7 |
| clr_vec_i | input | $clog2(NUM_VEC) | Vector to clear |
| cpu_status_i | input | 16 | Current processor status; bits 15:13 give the level |
| take_req_i | input | 1 | Processor can take an interrupt now |
| reti_req_i | input | 1 | Processor is returning from an interrupt |
| saved_status_i | input | 16 | Status word at the top of the stack |
| irq_req_o | output | 1 | A source qualifies against the current level |
| pend_cnt_o | output | $clog2(NUM_VEC)+1 | Outstanding request count |
| accept_o | output | 1 | One-cycle pulse: interrupt taken |
| chain_o | output | 1 | One-cycle pulse: return chains to a new source |
| ret_o | output | 1 | One-cycle pulse: ordinary return |
| win_vec_o | output | $clog2(NUM_VEC) | Registered winning vector |
| pc_addr_o | output | 24 | Registered vector-table entry address |
| bank_addr_o | output | 24 | Registered bank-byte address |
| new_status_o | output | 16 | Registered status word to install |

## Verification
The bench builds the block with NUM_VEC = 8, which makes the count 4 bits wide. Saturation at 15 can then be reached with a short burst of level changes. Four arithmetic level maps over all eight vectors are each tried against all eight current levels and all eight saved levels. This covers every threshold and cases where a lower-numbered vector with a worse level beats a more urgent one. Directed sequences cover the counting rules for a repeated level, a clear of an idle vector, an empty clear, and a set and clear of the same vector in one cycle.

// File: rtl/ilvl_pkg.sv
package ilvl_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 3'd7;
endpackage

// File: rtl/ilvl_store.sv
module ilvl_store
  import ilvl_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int CNT_W   = $clog2(NUM_VEC) + 1,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_valid_i,
  input  logic [VEC_W-1:0]         set_vec_i,
  input  lvl_t                     set_level_i,
  input  logic                     clr_valid_i,
  input  logic [VEC_W-1:0]         clr_vec_i,
  output logic [NUM_VEC*LVL_W-1:0] lvl_flat_o,
  output logic [CNT_W-1:0]         cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  lvl_t             lvl_q [NUM_VEC];
  logic [CNT_W-1:0] cnt_q;
  logic             same_vec, bump, drop;

  assign same_vec = set_valid_i && clr_valid_i && (set_vec_i == clr_vec_i);
  assign bump     = set_valid_i && !same_vec && (lvl_q[set_vec_i] != set_level_i);
  assign drop     = clr_valid_i && (lvl_q[clr_vec_i] != LVL_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_VEC; i++) lvl_q[i] <= LVL_IDLE;
      cnt_q <= '0;
    end else begin
      if (set_valid_i) lvl_q[set_vec_i] <= set_level_i;
      if (clr_valid_i) lvl_q[clr_vec_i] <= LVL_IDLE;
      case ({bump, drop})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_flat
    assign lvl_flat_o[g*LVL_W +: LVL_W] = lvl_q[g];
  end
  assign cnt_o = cnt_q;

  // R3: a cleared vector is idle on the next cycle
  assert_clear_idle_R3: assert property (@(posedge clk) disable iff (rst)
    clr_valid_i |=> (lvl_q[$past(clr_vec_i)] == LVL_IDLE));
  // R3: the count does not wrap below zero
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !set_valid_i) |=> (cnt_q == '0));
  // R2: rewriting an unchanged level leaves the count alone
  assert_same_level_R2: assert property (@(posedge clk) disable iff (rst)
    (set_valid_i && !clr_valid_i && lvl_q[set_vec_i] == set_level_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ilvl_arb.sv
module ilvl_arb
  import ilvl_pkg::*;
#(
  parameter int NUM_VEC = 256,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC*LVL_W-1:0] lvl_flat_i,
  input  lvl_t                     thr_i,
  output logic                     hit_o,
  output logic [VEC_W-1:0]         idx_o,
  output lvl_t                     lvl_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = LVL_IDLE;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (lvl_flat_i[i*LVL_W +: LVL_W] < thr_i) begin
        hit_o = 1'b1;
        idx_o = VEC_W'(i);
        lvl_o = lvl_flat_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/ilvl_dispatch.sv
module ilvl_dispatch
  import ilvl_pkg::*;
#(
  parameter int          NUM_VEC = 256,
  parameter int          ADDR_W  = 24,
  parameter int unsigned VT_TOP  = 32'h00FF_FFFC,
  parameter int          STAT_W  = 16,
  parameter int          S_BIT   = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         set_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0]   set_vec_i,
  input  logic [2:0]                   set_level_i,
  input  logic                         clr_valid_i,
  input  logic [$clog2(NUM_VEC)-1:0]   clr_vec_i,
  input  logic [STAT_W-1:0]            cpu_status_i,
  input  logic                         take_req_i,
  input  logic                         reti_req_i,
  input  logic [STAT_W-1:0]            saved_status_i,
  output logic                         irq_req_o,
  output logic [$clog2(NUM_VEC):0]     pend_cnt_o,
  output logic                         accept_o,
  output logic                         chain_o,
  output logic                         ret_o,
  output logic [$clog2(NUM_VEC)-1:0]   win_vec_o,
  output logic [ADDR_W-1:0]            pc_addr_o,
  output logic [ADDR_W-1:0]            bank_addr_o,
  output logic [STAT_W-1:0]            new_status_o
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int CNT_W = VEC_W + 1;
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(VT_TOP);

  logic [NUM_VEC*LVL_W-1:0] lvl_flat;
  logic [CNT_W-1:0]         cnt;
  logic                     hit_cur, hit_sav;
  logic [VEC_W-1:0]         idx_cur, idx_sav;
  lvl_t                     lvl_cur, lvl_sav;
  logic                     live;

  ilvl_store #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst(rst),
    .set_valid_i(set_valid_i), .set_vec_i(set_vec_i), .set_level_i(set_level_i),
    .clr_valid_i(clr_valid_i), .clr_vec_i(clr_vec_i),
    .lvl_flat_o(lvl_flat), .cnt_o(cnt)
  );

  ilvl_arb #(.NUM_VEC(NUM_VEC)) arb_cur_i (
    .lvl_flat_i(lvl_flat), .thr_i(cpu_status_i[STAT_W-1 -: LVL_W]),
    .hit_o(hit_cur), .idx_o(idx_cur), .lvl_o(lvl_cur)
  );

  ilvl_arb #(.NUM_VEC(NUM_VEC)) arb_sav_i (
    .lvl_flat_i(lvl_flat), .thr_i(saved_status_i[STAT_W-1 -: LVL_W]),
    .hit_o(hit_sav), .idx_o(idx_sav), .lvl_o(lvl_sav)
  );

  assign live      = (cnt != '0);
  assign irq_req_o = live && hit_cur;

  function automatic logic [STAT_W-1:0] install(input logic [STAT_W-1:0] base, input lvl_t lv);
    logic [STAT_W-1:0] r;
    r = base;
    r[S_BIT] = 1'b1;
    r[STAT_W-1 -: LVL_W] = lv;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] entry(input logic [VEC_W-1:0] v);
    return TOP_A - (ADDR_W'(v) << 2);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o     <= 1'b0;
      chain_o      <= 1'b0;
      ret_o        <= 1'b0;
      win_vec_o    <= '0;
      pc_addr_o    <= TOP_A;
      bank_addr_o  <= TOP_A + ADDR_W'(2);
      new_status_o <= '0;
    end else begin
      accept_o <= 1'b0;
      chain_o  <= 1'b0;
      ret_o    <= 1'b0;
      if (reti_req_i) begin
        if (live && hit_sav) begin
          chain_o      <= 1'b1;
          win_vec_o    <= idx_sav;
          pc_addr_o    <= entry(idx_sav);
          bank_addr_o  <= entry(idx_sav) + ADDR_W'(2);
          new_status_o <= install(saved_status_i, lvl_sav);
        end else begin
          ret_o <= 1'b1;
        end
      end else if (take_req_i && live && hit_cur) begin
        accept_o     <= 1'b1;
        win_vec_o    <= idx_cur;
        pc_addr_o    <= entry(idx_cur);
        bank_addr_o  <= entry(idx_cur) + ADDR_W'(2);
        new_status_o <= install(cpu_status_i, lvl_cur);
      end
    end
  end

  assign pend_cnt_o = cnt;

  // R9: at most one of the three outcome strobes at a time
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({accept_o, chain_o, ret_o}));
  // R6: an accept follows a take request made with a nonzero count
  assert_accept_cause_R6: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> ($past(take_req_i) && $past(cnt) != '0));
  // R6: the accepted level is strictly below the level held at request time
  assert_accept_level_R6: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> (new_status_o[STAT_W-1 -: LVL_W] < $past(cpu_status_i[STAT_W-1 -: LVL_W])));
  // R8: a taken or chained interrupt runs on the supervisor stack
  assert_super_stack_R8: assert property (@(posedge clk) disable iff (rst)
    (accept_o || chain_o) |-> new_status_o[S_BIT]);
endmodule

// File: tb/ilvl_dispatch_tb.sv
module ilvl_dispatch_tb_top;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_valid = 1'b0, clr_valid = 1'b0;
  logic [2:0]  set_vec = '0, clr_vec = '0, set_level = '0;
  logic [15:0] cpu_status = '0, saved_status = '0;
  logic        take_req = 1'b0, reti_req = 1'b0;
  logic        irq_req, accept, chain, ret;
  logic [3:0]  pend_cnt;
  logic [2:0]  win_vec;
  logic [23:0] pc_addr, bank_addr;
  logic [15:0] new_status;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_lvl [NV];
  int m_cnt, m_win;

  always #5 clk = ~clk;

  ilvl_dispatch #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rst(rst),
    .set_valid_i(set_valid), .set_vec_i(set_vec), .set_level_i(set_level),
    .clr_valid_i(clr_valid), .clr_vec_i(clr_vec),
    .cpu_status_i(cpu_status), .take_req_i(take_req), .reti_req_i(reti_req),
    .saved_status_i(saved_status),
    .irq_req_o(irq_req), .pend_cnt_o(pend_cnt), .accept_o(accept), .chain_o(chain),
    .ret_o(ret), .win_vec_o(win_vec), .pc_addr_o(pc_addr), .bank_addr_o(bank_addr),
    .new_status_o(new_status)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int win_of(input int thr);
    int r = -1;
    for (int i = NV - 1; i >= 0; i--) if (m_lvl[i] < thr) r = i;
    return r;
  endfunction

  function automatic longint pc_of(input int v);
    return (64'hFFFFFC - 4 * v) & 64'hFFFFFF;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) m_lvl[i] = 7;
    m_cnt = 0;
    m_win = 0;
  endtask

  task automatic do_op(input bit s, input int sv, input int sl, input bit c, input int cv);
    set_valid = s; set_vec = 3'(sv); set_level = 3'(sl);
    clr_valid = c; clr_vec = 3'(cv);
    @(negedge clk);
    set_valid = 1'b0; clr_valid = 1'b0;
    if (s && !(c && cv == sv) && m_lvl[sv] != sl && m_cnt != 15) m_cnt++;
    if (c && m_lvl[cv] < 7 && m_cnt != 0) m_cnt--;
    if (s) m_lvl[sv] = sl;
    if (c) m_lvl[cv] = 7;
  endtask

  task automatic do_take(input int cur);
    int w;
    cpu_status = {3'(cur), 13'h0A5A};
    take_req = 1'b1;
    #1;
    w = (m_cnt != 0) ? win_of(cur) : -1;
    chk("R5 irq_req", irq_req, (w >= 0));
    @(negedge clk);
    take_req = 1'b0;
    if (w >= 0) begin
      chk("R6 accept", accept, 1);
      chk("R6 win_vec", win_vec, w);
      chk("R7 pc_addr", pc_addr, pc_of(w));
      chk("R7 bank_addr", bank_addr, (pc_of(w) + 2) & 64'hFFFFFF);
      chk("R8 new_status", new_status, (m_lvl[w] << 13) | 16'h0A7A);
      m_win = w;
    end else begin
      chk("R10 accept", accept, 0);
      chk("R10 win_vec", win_vec, m_win);
    end
  endtask

  task automatic do_reti(input int sv);
    int w;
    saved_status = {3'(sv), 13'h1214};
    cpu_status = {3'd7, 13'h0A5A};
    reti_req = 1'b1;
    take_req = 1'b1;
    @(negedge clk);
    reti_req = 1'b0;
    take_req = 1'b0;
    w = (m_cnt != 0) ? win_of(sv) : -1;
    chk("R9 accept", accept, 0);
    chk("R9 chain", chain, (w >= 0));
    chk("R9 ret", ret, (w < 0));
    if (w >= 0) begin
      chk("R9 win_vec", win_vec, w);
      chk("R9 new_status", new_status, (m_lvl[w] << 13) | 16'h1234);
      chk("R7 chain pc_addr", pc_addr, pc_of(w));
      m_win = w;
    end
  endtask

  initial begin
    do_reset();
    chk("R1 count", pend_cnt, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 strobes", {accept, chain, ret}, 0);
    chk("R1 win_vec", win_vec, 0);
    chk("R1 pc_addr", pc_addr, 24'hFFFFFC);
    do_op(1, 3, 7, 0, 0);
    chk("R1 R2 idle rewrite", pend_cnt, 0);
    do_op(1, 3, 2, 0, 0);
    chk("R2 set counts", pend_cnt, 1);
    do_op(1, 3, 2, 0, 0);
    chk("R2 same level", pend_cnt, 1);
    do_op(0, 0, 0, 1, 5);
    chk("R3 clear idle", pend_cnt, 1);
    do_op(0, 0, 0, 1, 3);
    chk("R3 clear active", pend_cnt, 0);
    do_op(0, 0, 0, 1, 3);
    chk("R3 empty clear", pend_cnt, 0);
    do_op(1, 2, 1, 1, 2);
    chk("R3 clear wins count", pend_cnt, 0);
    do_take(7);
    do_op(1, 2, 1, 0, 0);
    do_op(1, 2, 4, 1, 2);
    chk("R3 clear wins decrement", pend_cnt, 0);
    do_take(7);
    for (int k = 0; k < 20; k++) do_op(1, 0, 1 + (k % 2), 0, 0);
    chk("R4 saturate", pend_cnt, 15);
    do_op(1, 4, 3, 0, 0);
    chk("R4 hold max", pend_cnt, 15);
    do_take(7);
    do_take(1);
    do_reset();
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < NV; v++) do_op(1, v, (v * (2 * p + 1) + 2 * p + 1) % 8, 0, 0);
      chk("R2 R4 sweep count", pend_cnt, m_cnt);
      for (int cur = 0; cur < 8; cur++) do_take(cur);
      for (int sv = 0; sv < 8; sv++) do_reti(sv);
    end
    for (int v = 0; v < NV; v++) do_op(0, 0, 0, 1, v);
    chk("R3 all cleared", pend_cnt, m_cnt);
    do_take(7);
    do_reti(7);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule